// File: doc/BRIEF.md
# DMA Bus Arbiter with Byte-Lane Swapping

This block shares one host-memory bus master port between two DMA requesters: a transmit engine and a receive engine. At most one of them holds the bus at a time. A grant is given only between transactions and is held until the owning requester signals that its transaction is finished, so a burst is never interrupted. A mode input selects the contention policy. In receive-first mode the receive engine wins whenever both engines ask. In fair mode the two engines take turns, round-robin.

Each requester marks its transaction as either a descriptor access or a data-buffer access. Two independent endianness inputs set the byte order, one for descriptor traffic and one for buffer traffic. In big-endian mode the byte lanes of each word are mirrored. In little-endian mode data passes through unchanged. The mirroring applies both to write data sent to memory and to read data returned to the owning requester. The byte order is latched when the grant is given and holds for the whole transaction.

Top module: `dma_bus_arbiter`

## Requirements
- R1: Out of reset and while no transaction is active, `tx_gnt_o`, `rx_gnt_o` and `bus_active_o` are 0, and `bus_wdata_o`, `tx_rdata_o` and `rx_rdata_o` are all zero. At most one grant is ever high.
- R2: When no grant is active and at least one request is high at a rising clock edge, the chosen requester's grant is high from that edge on. A lone requester always wins.
- R3: A grant stays high until the owner's done input is sampled high. The grant falls at that edge, and no new grant is given at that same edge, so at least one cycle with no grant separates two transactions.
- R4: With `fair_mode_i` = 0, the receive requester wins whenever both requesters ask in the same idle cycle.
- R5: With `fair_mode_i` = 1 and both requesters asking, the winner is the requester that did not complete the most recent transaction. Every completed transaction updates this history, in both modes. After reset the receive requester is favoured.
- R6: For a descriptor access (`*_is_desc_i` = 1), `desc_big_i` = 1 mirrors the byte lanes (lane 0 with lane 3, lane 1 with lane 2, lane k = bits 8k+7:8k), and `desc_big_i` = 0 passes the word unchanged.
- R7: For a buffer access (`*_is_desc_i` = 0), `buf_big_i` applies the same choice between mirroring and pass-through.
- R8: The owner's write data appears on `bus_wdata_o`, and `bus_rdata_i` appears on the owner's read-data output. Both paths use the same lane mapping. The read-data output of the requester that is not the owner is zero.
- R9: The byte order for a transaction comes from the access-type input and the endianness inputs sampled at the grant edge. Changing them during the transaction has no effect on the data paths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| fair_mode_i | input | 1 | 1: round-robin, 0: receive requester first |
| desc_big_i | input | 1 | Byte order for descriptor accesses, 1 = mirrored |
| buf_big_i | input | 1 | Byte order for buffer accesses, 1 = mirrored |
| tx_req_i | input | 1 | Transmit requester asks for the bus |
| tx_is_desc_i | input | 1 | Transmit access is a descriptor access |
| tx_done_i | input | 1 | Transmit owner finishes its transaction |
| tx_wdata_i | input | DATA_W | Transmit write data |
| tx_gnt_o | output | 1 | Transmit requester owns the bus |
| tx_rdata_o | output | DATA_W | Read data to transmit requester |
| rx_req_i | input | 1 | Receive requester asks for the bus |
| rx_is_desc_i | input | 1 | Receive access is a descriptor access |
| rx_done_i | input | 1 | Receive owner finishes its transaction |
| rx_wdata_i | input | DATA_W | Receive write data |
| rx_gnt_o | output | 1 | Receive requester owns the bus |
| rx_rdata_o | output | DATA_W | Read data to receive requester |
| bus_active_o | output | 1 | A transaction owns the bus master port |
| bus_wdata_o | output | DATA_W | Write data to memory |
| bus_rdata_i | input | DATA_W | Read data from memory |

## Verification
The bench builds the block with its default `DATA_W` of 32, which gives four byte lanes. With four lanes the mirroring both exchanges the outer pair and exchanges the inner pair, and the distinct test words (`11223344`, `A1B2C3D4`, `55667788`) show any lane misplacement. A vector table covers both policies and every combination of access type and endianness control, and it relies on the round-robin history carried from one vector to the next. Directed tests cover holding the grant during contention, endianness changes in the middle of a transaction, the idle gap, reset in the middle of a grant, and the favoured requester after reset.

// File: rtl/dba_pkg.sv
// Package dba_pkg
// Shared types for the DMA bus arbiter: the bus-owner encoding.
// Assumes two requesters only (transmit and receive).
package dba_pkg;
    typedef enum logic [1:0] {
        OWN_NONE = 2'd0,
        OWN_TX   = 2'd1,
        OWN_RX   = 2'd2
    } owner_e;
endpackage

// File: rtl/dba_policy.sv
// Module dba_policy
// Combinational winner selection for one idle cycle. In receive-first mode
// the receive requester wins contention; in fair mode the favour flag breaks
// the tie. Assumes it is consulted only while the bus is free.
module dba_policy
    import dba_pkg::*;
(
    input  logic   tx_req,
    input  logic   rx_req,
    input  logic   fair_mode,
    input  logic   favor_tx,
    output owner_e pick
);
    // Purpose: choose the next owner from the current requests.
    always_comb begin
        if (tx_req && rx_req) begin
            if (fair_mode && favor_tx) pick = OWN_TX;
            else                       pick = OWN_RX;
        end else if (rx_req) begin
            pick = OWN_RX;
        end else if (tx_req) begin
            pick = OWN_TX;
        end else begin
            pick = OWN_NONE;
        end
    end
endmodule

// File: rtl/dba_grant_fsm.sv
// Module dba_grant_fsm
// Holds the current bus owner and the byte-order choice of its transaction.
// A grant starts only from the free state, and it ends when the owner signals
// done; the completed owner then loses the round-robin favour.
// Assumes done is meaningful only from the current owner.
module dba_grant_fsm
    import dba_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  owner_e pick,
    input  logic   tx_done,
    input  logic   rx_done,
    input  logic   tx_is_desc,
    input  logic   rx_is_desc,
    input  logic   desc_big,
    input  logic   buf_big,
    output owner_e owner_q,
    output logic   swap_q,
    output logic   favor_tx_q
);
    logic owner_done;
    logic tx_mirror;
    logic rx_mirror;

    // Purpose: decode whether the present owner is finishing.
    always_comb begin
        owner_done = ((owner_q == OWN_TX) && tx_done) ||
                     ((owner_q == OWN_RX) && rx_done);
        tx_mirror  = tx_is_desc ? desc_big : buf_big;
        rx_mirror  = rx_is_desc ? desc_big : buf_big;
    end

    // Purpose: grant, hold, release and round-robin history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner_q    <= OWN_NONE;
            swap_q     <= 1'b0;
            favor_tx_q <= 1'b0;
        end else if (owner_q == OWN_NONE) begin
            owner_q <= pick;
            case (pick)
                OWN_TX:  swap_q <= tx_mirror;
                OWN_RX:  swap_q <= rx_mirror;
                default: swap_q <= 1'b0;
            endcase
        end else if (owner_done) begin
            favor_tx_q <= (owner_q == OWN_RX);
            owner_q    <= OWN_NONE;
            swap_q     <= 1'b0;
        end
    end
endmodule

// File: rtl/dba_lane_swap.sv
// Module dba_lane_swap
// Mirrors the byte lanes of a word when enabled, else passes it through.
// Assumes DATA_W is a whole number of bytes.
module dba_lane_swap #(
    parameter int DATA_W = 32
) (
    input  logic              en,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    localparam int LANES = DATA_W / 8;

    // Purpose: one multiplexer per byte lane.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign dout[g*8 +: 8] = en ? din[(LANES-1-g)*8 +: 8] : din[g*8 +: 8];
    end
endmodule

// File: rtl/dma_bus_arbiter.sv
// Module dma_bus_arbiter
// Shares one memory bus master port between a transmit and a receive DMA
// requester. Selectable contention policy (receive-first or round-robin),
// grant held until done, and byte-lane mirroring chosen per transaction from
// separate descriptor and buffer endianness controls.
// Assumes requesters keep req high until granted and pulse done once.
module dma_bus_arbiter
    import dba_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fair_mode_i,
    input  logic              desc_big_i,
    input  logic              buf_big_i,
    input  logic              tx_req_i,
    input  logic              tx_is_desc_i,
    input  logic              tx_done_i,
    input  logic [DATA_W-1:0] tx_wdata_i,
    output logic              tx_gnt_o,
    output logic [DATA_W-1:0] tx_rdata_o,
    input  logic              rx_req_i,
    input  logic              rx_is_desc_i,
    input  logic              rx_done_i,
    input  logic [DATA_W-1:0] rx_wdata_i,
    output logic              rx_gnt_o,
    output logic [DATA_W-1:0] rx_rdata_o,
    output logic              bus_active_o,
    output logic [DATA_W-1:0] bus_wdata_o,
    input  logic [DATA_W-1:0] bus_rdata_i
);
    localparam int LANES = DATA_W / 8;

    owner_e            pick;
    owner_e            owner;
    logic              txn_swap;
    logic              favor_tx;
    logic [DATA_W-1:0] wsel;
    logic [DATA_W-1:0] wswap;
    logic [DATA_W-1:0] rswap;

    initial begin
        if (LANES * 8 != DATA_W) $error("DATA_W must be a multiple of 8");
    end

    dba_policy u_policy (
        .tx_req    (tx_req_i),
        .rx_req    (rx_req_i),
        .fair_mode (fair_mode_i),
        .favor_tx  (favor_tx),
        .pick      (pick)
    );

    dba_grant_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .pick       (pick),
        .tx_done    (tx_done_i),
        .rx_done    (rx_done_i),
        .tx_is_desc (tx_is_desc_i),
        .rx_is_desc (rx_is_desc_i),
        .desc_big   (desc_big_i),
        .buf_big    (buf_big_i),
        .owner_q    (owner),
        .swap_q     (txn_swap),
        .favor_tx_q (favor_tx)
    );

    // Purpose: route the owner's write data toward the bus.
    always_comb begin
        case (owner)
            OWN_TX:  wsel = tx_wdata_i;
            OWN_RX:  wsel = rx_wdata_i;
            default: wsel = '0;
        endcase
    end

    dba_lane_swap #(.DATA_W(DATA_W)) u_wr_swap (
        .en   (txn_swap),
        .din  (wsel),
        .dout (wswap)
    );

    dba_lane_swap #(.DATA_W(DATA_W)) u_rd_swap (
        .en   (txn_swap),
        .din  (bus_rdata_i),
        .dout (rswap)
    );

    // Purpose: drive grants and steer read data to the owner only.
    always_comb begin
        tx_gnt_o     = (owner == OWN_TX);
        rx_gnt_o     = (owner == OWN_RX);
        bus_active_o = (owner != OWN_NONE);
        bus_wdata_o  = wswap;
        tx_rdata_o   = (owner == OWN_TX) ? rswap : '0;
        rx_rdata_o   = (owner == OWN_RX) ? rswap : '0;
    end
endmodule

// File: rtl/dba_checks.sv
// Module dba_checks
// Property checker for dma_bus_arbiter, attached by bind. Keeps its own
// round-robin history to check the fair policy.
module dba_checks (
    input logic clk,
    input logic rst_n,
    input logic fair_mode_i,
    input logic tx_req_i,
    input logic rx_req_i,
    input logic tx_done_i,
    input logic rx_done_i,
    input logic tx_gnt_o,
    input logic rx_gnt_o,
    input logic txn_swap
);
    logic chk_favor_tx;
    logic idle;

    // Purpose: free-bus flag for the properties.
    always_comb idle = !tx_gnt_o && !rx_gnt_o;

    // Purpose: independent model of who completed last.
    always_ff @(posedge clk) begin
        if (!rst_n)                      chk_favor_tx <= 1'b0;
        else if (tx_gnt_o && tx_done_i)  chk_favor_tx <= 1'b0;
        else if (rx_gnt_o && rx_done_i)  chk_favor_tx <= 1'b1;
    end

    // R1
    one_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tx_gnt_o, rx_gnt_o}));

    // R3
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_gnt_o && !tx_done_i) |=> tx_gnt_o);

    // R3
    rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_gnt_o && !rx_done_i) |=> rx_gnt_o);

    // R3
    gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((tx_gnt_o && tx_done_i) || (rx_gnt_o && rx_done_i)) |=> idle);

    // R2
    tx_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && !tx_req_i) |=> !tx_gnt_o);

    // R4
    rx_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && tx_req_i && rx_req_i && !fair_mode_i) |=> rx_gnt_o);

    // R5
    fair_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && tx_req_i && rx_req_i && fair_mode_i) |=>
            (tx_gnt_o == $past(chk_favor_tx)));

    // R9
    swap_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((tx_gnt_o || rx_gnt_o) && $past(tx_gnt_o || rx_gnt_o)) |-> $stable(txn_swap));
endmodule

bind dma_bus_arbiter dba_checks u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fair_mode_i (fair_mode_i),
    .tx_req_i    (tx_req_i),
    .rx_req_i    (rx_req_i),
    .tx_done_i   (tx_done_i),
    .rx_done_i   (rx_done_i),
    .tx_gnt_o    (tx_gnt_o),
    .rx_gnt_o    (rx_gnt_o),
    .txn_swap    (txn_swap)
);

// File: tb/dma_bus_arbiter_tb.sv
module dma_bus_arbiter_tb;
    localparam int DW = 32;
    localparam logic [DW-1:0] TXW = 32'h11223344;
    localparam logic [DW-1:0] RXW = 32'hA1B2C3D4;
    localparam logic [DW-1:0] RDW = 32'h55667788;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fair = 1'b0, dbig = 1'b0, bbig = 1'b0;
    logic treq = 1'b0, tdesc = 1'b0, tdone = 1'b0;
    logic rreq = 1'b0, rdesc = 1'b0, rdone = 1'b0;
    logic tgnt, rgnt, bact;
    logic [DW-1:0] trd, rrd, bwd;
    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    dma_bus_arbiter #(.DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .fair_mode_i(fair), .desc_big_i(dbig),
        .buf_big_i(bbig), .tx_req_i(treq), .tx_is_desc_i(tdesc),
        .tx_done_i(tdone), .tx_wdata_i(TXW), .tx_gnt_o(tgnt), .tx_rdata_o(trd),
        .rx_req_i(rreq), .rx_is_desc_i(rdesc), .rx_done_i(rdone),
        .rx_wdata_i(RXW), .rx_gnt_o(rgnt), .rx_rdata_o(rrd),
        .bus_active_o(bact), .bus_wdata_o(bwd), .bus_rdata_i(RDW)
    );

    function automatic logic [31:0] mirror(input logic [31:0] d);
        return {d[7:0], d[15:8], d[23:16], d[31:24]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // win: 0 none, 1 transmit, 2 receive
    typedef struct packed {
        logic fair, dbig, bbig, treq, tdesc, rreq, rdesc;
        logic [1:0] win;
        logic swp;
    } vec_t;

    localparam vec_t VECS [0:8] = '{
        '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 2'd2, 1'b1}, // R4 R6
        '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 2'd2, 1'b1}, // R4 R7
        '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 2'd1, 1'b0}, // R5 R7
        '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 2'd2, 1'b1}, // R5 R7
        '{1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 2'd2, 1'b0}, // R2 R6
        '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 2'd1, 1'b1}, // R5 R6
        '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 2'd1, 1'b1}, // R2 R7
        '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 2'd2, 1'b0}, // R5 R7
        '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0}  // R1
    };

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [31:0] ew, er;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 tx_gnt reset", {31'b0, tgnt}, 0);
        check("R1 rx_gnt reset", {31'b0, rgnt}, 0);
        check("R1 bus_wdata reset", bwd, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle active", {31'b0, bact}, 0);

        foreach (VECS[i]) begin
            fair = VECS[i].fair; dbig = VECS[i].dbig; bbig = VECS[i].bbig;
            treq = VECS[i].treq; tdesc = VECS[i].tdesc;
            rreq = VECS[i].rreq; rdesc = VECS[i].rdesc;
            @(negedge clk);
            check($sformatf("R2 R4 R5 tx_gnt vec%0d", i), {31'b0, tgnt}, {31'b0, VECS[i].win == 2'd1});
            check($sformatf("R2 R4 R5 rx_gnt vec%0d", i), {31'b0, rgnt}, {31'b0, VECS[i].win == 2'd2});
            ew = (VECS[i].win == 2'd1) ? TXW : (VECS[i].win == 2'd2) ? RXW : 32'h0;
            if (VECS[i].swp) ew = mirror(ew);
            er = VECS[i].swp ? mirror(RDW) : RDW;
            check($sformatf("R6 R7 R8 wdata vec%0d", i), bwd, ew);
            check($sformatf("R8 tx_rdata vec%0d", i), trd, (VECS[i].win == 2'd1) ? er : 32'h0);
            check($sformatf("R8 rx_rdata vec%0d", i), rrd, (VECS[i].win == 2'd2) ? er : 32'h0);
            treq = 1'b0; rreq = 1'b0;
            if (VECS[i].win != 2'd0) begin
                tdone = (VECS[i].win == 2'd1);
                rdone = (VECS[i].win == 2'd2);
                @(negedge clk);
                tdone = 1'b0; rdone = 1'b0;
                check($sformatf("R3 released vec%0d", i), {31'b0, bact}, 0);
            end
        end

        // R3 R9: hold under contention, controls change mid-transaction
        fair = 1'b0; dbig = 1'b0; bbig = 1'b0; tdesc = 1'b0;
        treq = 1'b1;
        @(negedge clk);
        check("R2 lone tx grant", {31'b0, tgnt}, 1);
        rreq = 1'b1; bbig = 1'b1; dbig = 1'b1; tdesc = 1'b1;
        repeat (4) @(negedge clk);
        check("R3 tx held", {31'b0, tgnt}, 1);
        check("R3 rx waits", {31'b0, rgnt}, 0);
        check("R9 wdata unchanged", bwd, TXW);
        check("R9 rdata unchanged", trd, RDW);
        treq = 1'b0; tdone = 1'b1;
        @(negedge clk);
        tdone = 1'b0;
        check("R3 idle gap tx", {31'b0, tgnt}, 0);
        check("R3 idle gap rx", {31'b0, rgnt}, 0);
        rdesc = 1'b0;
        @(negedge clk);
        check("R2 rx after gap", {31'b0, rgnt}, 1);
        check("R7 rx buf mirrored", bwd, mirror(RXW));

        // R1: reset in the middle of a grant
        rst_n = 1'b0; rreq = 1'b0;
        @(negedge clk);
        check("R1 reset drops grant", {31'b0, rgnt}, 0);
        check("R1 reset clears wdata", bwd, 0);
        check("R1 reset clears rdata", rrd, 0);
        rst_n = 1'b1;

        // R5: receive favoured after reset in fair mode
        fair = 1'b1; treq = 1'b1; rreq = 1'b1;
        @(negedge clk);
        check("R5 rx favoured after reset", {31'b0, rgnt}, 1);
        rreq = 1'b0; rdone = 1'b1;
        @(negedge clk);
        rdone = 1'b0;
        @(negedge clk);
        check("R5 tx next", {31'b0, tgnt}, 1);
        treq = 1'b0; tdone = 1'b1;
        @(negedge clk);
        tdone = 1'b0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule